// File: doc/BRIEF.md
# Banked GPIO Controller with Event Capture

A memory-mapped general-purpose I/O block built from a parameterized number of identical banks. Each bank owns up to 32 pins and a window of eight 32-bit registers. These registers set pin direction, output value and open-drain drive, and configure how each input pin raises an event: rising edge, falling edge, both edges or high level. Inputs cross into the clock domain through a two-flop synchronizer before detection. A detected event sets a sticky pending bit, and software clears that bit by writing a one to it.

The pending bits of all banks are gated by their per-pin enable registers and merged into a single interrupt line. A separate wake output pulses for one cycle each time an event is captured on an enabled pin, including when the pending bit was already set. Software reaches the registers through a plain single-cycle bus. Reads return data combinationally in the same cycle. Writes take effect at the clock edge.

Top module: `gpio_banked`

## Requirements
- R1: Bank n occupies byte addresses n*0x20 to n*0x20+0x1F. Within a bank, word offsets are 0x00 open-drain select, 0x04 pin value, 0x08 direction, 0x0C edge polarity, 0x10 any-edge select, 0x14 interrupt enable, 0x18 level select and 0x1C pending. A read (bus_en=1, bus_we=0) returns the addressed register in the same cycle. A read of an address beyond the last bank, or a cycle without a read, returns 0.
- R2: After reset, the direction register holds all ones within the bank width (every pin an input). All other registers hold 0, and irq and wake are low.
- R3: A direction bit of 0 drives the pin, with pin_out following the value register. A direction bit of 1 releases the pin. Reading the value register returns, for input pins, the pin level after two clock edges of synchronization and, for output pins, the stored value.
- R4: With its open-drain bit at 1, an output pin is driven only while its value is 0. pin_oe is low when the value is 1.
- R5: With any-edge select at 1, a pin flags both rising and falling edges whatever its polarity and level bits. The pending bit is visible after the third rising clock edge following the pin change.
- R6: With any-edge 0 and level 0, a pin flags only rising edges when its polarity bit is 1 and only falling edges when it is 0.
- R7: With any-edge 0 and level 1, a pin flags an event on every cycle its synchronized input is high.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write keeps the bit set.
- R9: Bits at or above a bank's width read as 0 in every register, never become pending, and never drive pin_oe.
- R10: irq is high exactly when some bank has a pending bit whose interrupt enable bit is 1.
- R11: wake is a one-cycle pulse in the cycle after an event is captured on a pin whose interrupt enable bit is 1, even if that pin was already pending. Events on disabled pins do not pulse it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(NUM_BANKS)+5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | NUM_BANKS*32 | Pin levels from pads, bank n at bits n*32 up |
| pin_out | output | NUM_BANKS*32 | Output value to pads |
| pin_oe | output | NUM_BANKS*32 | Pad drive enable |
| irq | output | 1 | Combined enabled-pending interrupt |
| wake | output | 1 | Event pulse for enabled pins |

## Verification
The bench builds three banks with widths 32, 20 and 8. The bank count is not a power of two, so one address window decodes to no bank and must read as zero. The 20- and 8-pin banks expose the masking of upper bits in registers, pending state and drive enables. The full 32-pin bank covers the case where no bit is masked. Because the interrupt is merged across banks, enabling a pending pin in one bank while another bank is cleared shows that the merge spans all banks.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int WIDTH_FIELD_W = 6;
    localparam int BANK_SPAN_LOG2 = 5;

    typedef enum logic [2:0] {
        REG_OPEN_DRAIN = 3'd0,
        REG_VALUE      = 3'd1,
        REG_DIR        = 3'd2,
        REG_EDGE_POL   = 3'd3,
        REG_ANY_EDGE   = 3'd4,
        REG_IRQ_EN     = 3'd5,
        REG_LEVEL      = 3'd6,
        REG_PENDING    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [PINS_PER_BANK-1:0] open_drain;
        logic [PINS_PER_BANK-1:0] value;
        logic [PINS_PER_BANK-1:0] dir;
        logic [PINS_PER_BANK-1:0] edge_pol;
        logic [PINS_PER_BANK-1:0] any_edge;
        logic [PINS_PER_BANK-1:0] irq_en;
        logic [PINS_PER_BANK-1:0] level;
        logic [PINS_PER_BANK-1:0] pending;
        logic [PINS_PER_BANK-1:0] prev;
        logic                     wake;
    } bank_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign q = sy_q.s2;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] edge_pol,
    input  logic [WIDTH-1:0] any_edge,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] evt
);

    logic [WIDTH-1:0] rise, fall, edge_mode;

    always_comb begin
        rise      = cur & ~prev;
        fall      = ~cur & prev;
        edge_mode = ~any_edge & ~level;
        // Priority: any-edge, then level-high, then polarity-selected edge
        evt = (any_edge & (rise | fall))
            | (~any_edge & level & cur)
            | (edge_mode & edge_pol & rise)
            | (edge_mode & ~edge_pol & fall);
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_banked_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  reg_sel_e                 reg_sel,
    input  logic [31:0]              wdata,
    output logic [31:0]              rd_data,
    input  logic [PINS_PER_BANK-1:0] pin_in,
    output logic [PINS_PER_BANK-1:0] pin_out,
    output logic [PINS_PER_BANK-1:0] pin_oe,
    output logic                     irq,
    output logic                     wake
);

    localparam logic [PINS_PER_BANK-1:0] LIVE =
        (WIDTH >= PINS_PER_BANK) ? {PINS_PER_BANK{1'b1}}
                                 : ((32'd1 << WIDTH) - 32'd1);

    bank_state_t st_d, st_q, st_rst;
    logic [PINS_PER_BANK-1:0] pin_s;
    logic [PINS_PER_BANK-1:0] evt_raw, evt;

    gpio_sync #(.WIDTH(PINS_PER_BANK)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in & LIVE),
        .q     (pin_s)
    );

    gpio_evt_detect #(.WIDTH(PINS_PER_BANK)) u_detect (
        .cur      (pin_s),
        .prev     (st_q.prev),
        .edge_pol (st_q.edge_pol),
        .any_edge (st_q.any_edge),
        .level    (st_q.level),
        .evt      (evt_raw)
    );

    assign evt = evt_raw & LIVE;

    always_comb begin
        st_rst     = '0;
        st_rst.dir = LIVE;
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_s;
        if (wr_en) begin
            unique case (reg_sel)
                REG_OPEN_DRAIN: st_d.open_drain = wdata & LIVE;
                REG_VALUE:      st_d.value      = wdata & LIVE;
                REG_DIR:        st_d.dir        = wdata & LIVE;
                REG_EDGE_POL:   st_d.edge_pol   = wdata & LIVE;
                REG_ANY_EDGE:   st_d.any_edge   = wdata & LIVE;
                REG_IRQ_EN:     st_d.irq_en     = wdata & LIVE;
                REG_LEVEL:      st_d.level      = wdata & LIVE;
                REG_PENDING:    st_d.pending    = st_q.pending & ~wdata;
            endcase
        end
        // a fresh event overrides a clearing write in the same cycle
        st_d.pending = (st_d.pending | evt) & LIVE;
        st_d.wake    = |(evt & st_q.irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_OPEN_DRAIN: rd_data = st_q.open_drain;
            REG_VALUE:      rd_data = (st_q.dir & pin_s) | (~st_q.dir & st_q.value);
            REG_DIR:        rd_data = st_q.dir;
            REG_EDGE_POL:   rd_data = st_q.edge_pol;
            REG_ANY_EDGE:   rd_data = st_q.any_edge;
            REG_IRQ_EN:     rd_data = st_q.irq_en;
            REG_LEVEL:      rd_data = st_q.level;
            REG_PENDING:    rd_data = st_q.pending;
        endcase
    end

    assign pin_out = st_q.value;
    assign pin_oe  = ~st_q.dir & ~(st_q.open_drain & st_q.value) & LIVE;
    assign irq     = |(st_q.pending & st_q.irq_en);
    assign wake    = st_q.wake;

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_banked_pkg::*;
#(
    parameter int                      NUM_BANKS   = 2,
    parameter logic [NUM_BANKS*6-1:0]  BANK_WIDTHS = {6'd20, 6'd32}
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_en,
    input  logic                            bus_we,
    input  logic [$clog2(NUM_BANKS)+4:0]    bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic [NUM_BANKS*32-1:0]         pin_in,
    output logic [NUM_BANKS*32-1:0]         pin_out,
    output logic [NUM_BANKS*32-1:0]         pin_oe,
    output logic                            irq,
    output logic                            wake
);

    localparam int IDX_W  = $clog2(NUM_BANKS);
    localparam int ADDR_W = IDX_W + BANK_SPAN_LOG2;

    logic [IDX_W-1:0]     sel_bank;
    reg_sel_e             sel_reg;
    logic [31:0]          bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] irq_v, wake_v;
    logic                 unused_addr_lsb;

    assign sel_bank        = bus_addr[ADDR_W-1:BANK_SPAN_LOG2];
    assign sel_reg         = reg_sel_e'(bus_addr[4:2]);
    assign unused_addr_lsb = ^bus_addr[1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(
            .WIDTH (int'(BANK_WIDTHS[b*WIDTH_FIELD_W +: WIDTH_FIELD_W]))
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_en && bus_we && (sel_bank == IDX_W'(b))),
            .reg_sel (sel_reg),
            .wdata   (bus_wdata),
            .rd_data (bank_rd[b]),
            .pin_in  (pin_in [b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pin_out (pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pin_oe  (pin_oe [b*PINS_PER_BANK +: PINS_PER_BANK]),
            .irq     (irq_v[b]),
            .wake    (wake_v[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_en && !bus_we && (sel_bank == IDX_W'(b))) begin
                bus_rdata = bank_rd[b];
            end
        end
    end

    assign irq  = |irq_v;
    assign wake = |wake_v;

endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk #(
    parameter int                     NUM_BANKS   = 2,
    parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd20, 6'd32}
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_en,
    input logic                         bus_we,
    input logic [$clog2(NUM_BANKS)+4:0] bus_addr,
    input logic [31:0]                  bus_rdata,
    input logic [NUM_BANKS*32-1:0]      pin_out,
    input logic [NUM_BANKS*32-1:0]      pin_oe,
    input logic                         irq,
    input logic                         wake
);

    function automatic logic [31:0] live_of(input int b);
        logic [31:0] m;
        int w;
        m = '0;
        w = int'(BANK_WIDTHS[b*6 +: 6]);
        for (int i = 0; i < 32; i++) begin
            if (i < w) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [NUM_BANKS*32-1:0] used_pins();
        logic [NUM_BANKS*32-1:0] m;
        for (int b = 0; b < NUM_BANKS; b++) begin
            m[b*32 +: 32] = live_of(b);
        end
        return m;
    endfunction

    localparam logic [NUM_BANKS*32-1:0] USED = used_pins();

    logic bus_write, bus_read;
    int   rd_bank;
    assign bus_write = bus_en && bus_we;
    assign bus_read  = bus_en && !bus_we;
    assign rd_bank   = int'(bus_addr >> 5);

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_write |=> $stable(pin_out));

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_write |=> $stable(pin_oe));

    // R9
    unused_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~USED) == '0);

    // R9
    unused_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && rd_bank < NUM_BANKS) |-> (bus_rdata & ~live_of(rd_bank)) == 32'd0);

    // R1
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && rd_bank >= NUM_BANKS) |-> bus_rdata == 32'd0);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_write));

    // R11
    wake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !$past(bus_write)) |-> irq);

endmodule

bind gpio_banked gpio_banked_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK_WIDTHS (BANK_WIDTHS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .wake      (wake)
);

// File: tb/gpio_banked_test.sv
module gpio_banked_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;
    localparam logic [NB*6-1:0] WIDTHS = {6'd8, 6'd20, 6'd32};
    localparam int AW = $clog2(NB) + 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_en, bus_we;
    logic [AW-1:0]   bus_addr;
    logic [31:0]     bus_wdata, bus_rdata;
    logic [NB*32-1:0] pin_in, pin_out, pin_oe;
    logic            irq, wake;

    int checks = 0;
    int fails  = 0;
    int wake_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_banked #(.NUM_BANKS(NB), .BANK_WIDTHS(WIDTHS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq), .wake(wake)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_od[NB], m_val[NB], m_dir[NB], m_ec[NB], m_ei[NB];
    logic [31:0] m_en[NB], m_lvl[NB], m_pend[NB], m_s1[NB], m_s2[NB], m_prev[NB];
    logic        m_wake;

    function automatic logic [31:0] wm(input int b);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) if (i < int'(WIDTHS[b*6 +: 6])) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] m_read(input int addr);
        int b = addr >> 5;
        int r = (addr >> 2) & 7;
        if (b >= NB) return 32'd0;
        case (r)
            0: return m_od[b];
            1: return (m_dir[b] & m_s2[b]) | (~m_dir[b] & m_val[b]);
            2: return m_dir[b];
            3: return m_ec[b];
            4: return m_ei[b];
            5: return m_en[b];
            6: return m_lvl[b];
            default: return m_pend[b];
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] w, cur, pv, evt, wd;
        logic wk;
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_od[b] = 0; m_val[b] = 0; m_dir[b] = wm(b); m_ec[b] = 0; m_ei[b] = 0;
                m_en[b] = 0; m_lvl[b] = 0; m_pend[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
            end
            m_wake = 1'b0;
        end else begin
            wk = 1'b0;
            for (int b = 0; b < NB; b++) begin
                w = wm(b); cur = m_s2[b]; pv = m_prev[b]; evt = '0;
                for (int i = 0; i < 32; i++) begin
                    if (w[i]) begin
                        if (m_ei[b][i])       evt[i] = cur[i] != pv[i];
                        else if (m_lvl[b][i]) evt[i] = cur[i];
                        else if (m_ec[b][i])  evt[i] = cur[i] && !pv[i];
                        else                  evt[i] = !cur[i] && pv[i];
                    end
                end
                if ((evt & m_en[b]) != 0) wk = 1'b1;
                if (bus_en && bus_we && (int'(bus_addr) >> 5) == b) begin
                    wd = bus_wdata & w;
                    case ((int'(bus_addr) >> 2) & 7)
                        0: m_od[b] = wd;
                        1: m_val[b] = wd;
                        2: m_dir[b] = wd;
                        3: m_ec[b] = wd;
                        4: m_ei[b] = wd;
                        5: m_en[b] = wd;
                        6: m_lvl[b] = wd;
                        default: m_pend[b] = m_pend[b] & ~bus_wdata;
                    endcase
                end
                m_pend[b] = m_pend[b] | evt;
                m_prev[b] = cur;
                m_s2[b]   = m_s1[b];
                m_s1[b]   = pin_in[b*32 +: 32] & w;
            end
            m_wake = wk;
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, sampled between edges
    always @(negedge clk) begin
        logic [NB*32-1:0] e_oe, e_out;
        logic e_irq;
        #(CLK_PERIOD/4);
        if (rst_n) begin
            e_irq = 1'b0;
            for (int b = 0; b < NB; b++) begin
                e_out[b*32 +: 32] = m_val[b];
                e_oe[b*32 +: 32]  = ~m_dir[b] & ~(m_od[b] & m_val[b]) & wm(b);
                if ((m_pend[b] & m_en[b]) != 0) e_irq = 1'b1;
            end
            chk(64'(irq), 64'(e_irq), "R10 irq vs model");
            chk(64'(wake), 64'(m_wake), "R11 wake vs model");
            for (int b = 0; b < NB; b++) begin
                chk(64'(pin_out[b*32 +: 32]), 64'(e_out[b*32 +: 32]), "R3 pin_out vs model");
                chk(64'(pin_oe[b*32 +: 32]), 64'(e_oe[b*32 +: 32]), "R4 pin_oe vs model");
            end
            if (bus_en && !bus_we)
                chk(64'(bus_rdata), 64'(m_read(int'(bus_addr))), "R1 read vs model");
            if (wake) wake_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
        #(CLK_PERIOD/4);
        chk(64'(bus_rdata), 64'(exp), tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pin(input int idx, input logic v);
        @(negedge clk);
        pin_in[idx] = v;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int w0;
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(32'h08, 32'hFFFF_FFFF, "R2 bank0 direction");
        rd(32'h28, 32'h000F_FFFF, "R2 bank1 direction");
        rd(32'h48, 32'h0000_00FF, "R2 bank2 direction");
        rd(32'h54, 32'h0, "R2 bank2 enable");
        rd(32'h5C, 32'h0, "R2 bank2 pending");
        chk(64'(irq), 64'd0, "R2 irq low");
        chk(64'(wake), 64'd0, "R2 wake low");

        // R1 map, R9 width masking
        wr(32'h54, 32'hA5);
        rd(32'h54, 32'hA5, "R1 bank2 enable readback");
        wr(32'h4C, 32'hFFFF_FFFF);
        rd(32'h4C, 32'hFF, "R9 bank2 upper bits read 0");
        wr(32'h4C, 32'h0);
        wr(32'h54, 32'h0);
        rd(32'h60, 32'h0, "R1 unmapped window");

        // R3 direction and value
        wr(32'h08, 32'hFFFF_0000);
        wr(32'h04, 32'h0000_1234);
        chk(64'(pin_oe[15:0]), 64'hFFFF, "R3 outputs driven");
        chk(64'(pin_out[15:0]), 64'h1234, "R3 output value");
        @(negedge clk); pin_in[31:16] = 16'hABCD;
        idle(3);
        rd(32'h04, 32'hABCD_1234, "R3 mixed value read");

        // R4 open drain
        wr(32'h00, 32'hFF);
        chk(64'(pin_oe[15:0]), 64'hFFCB, "R4 open-drain drive");

        // R6 rising / falling
        wr(32'h2C, 32'h1);
        wr(32'h34, 32'h3);
        pin(32, 1'b1); idle(4);
        rd(32'h3C, 32'h1, "R6 rising captured");
        chk(64'(irq), 64'd1, "R10 irq on enabled pending");
        wr(32'h3C, 32'h1);
        rd(32'h3C, 32'h0, "R8 clear by writing one");
        chk(64'(irq), 64'd0, "R10 irq after clear");
        pin(33, 1'b1); idle(4);
        rd(32'h3C, 32'h0, "R6 falling pin ignores rise");
        pin(33, 1'b0); idle(4);
        rd(32'h3C, 32'h2, "R6 falling captured");
        wr(32'h3C, 32'h0);
        rd(32'h3C, 32'h2, "R8 zero write keeps bit");
        wr(32'h3C, 32'h2);

        // R5 both edges
        wr(32'h50, 32'h8);
        pin(67, 1'b1); idle(4);
        rd(32'h5C, 32'h8, "R5 rise with any-edge");
        wr(32'h5C, 32'h8);
        pin(67, 1'b0); idle(4);
        rd(32'h5C, 32'h8, "R5 fall with any-edge");
        wr(32'h5C, 32'h8);

        // R7 level, R8 event beats clear
        wr(32'h58, 32'h20);
        wr(32'h54, 32'h20);
        pin(69, 1'b1); idle(4);
        rd(32'h5C, 32'h20, "R7 level-high pending");
        wr(32'h5C, 32'h20);
        rd(32'h5C, 32'h20, "R8 event wins over clear");
        chk(64'(irq), 64'd1, "R10 irq level held");
        pin(69, 1'b0); idle(4);
        wr(32'h5C, 32'h20);
        rd(32'h5C, 32'h0, "R7 clears once low");

        // R11 wake re-signals while pending
        pin(32, 1'b0); idle(4);
        w0 = wake_cnt;
        pin(32, 1'b1); idle(5);
        chk(64'(wake_cnt - w0), 64'd1, "R11 wake pulse count");
        pin(32, 1'b0); idle(4);
        w0 = wake_cnt;
        pin(32, 1'b1); idle(5);
        chk(64'(wake_cnt - w0), 64'd1, "R11 wake while already pending");
        w0 = wake_cnt;
        pin(67, 1'b1); idle(5);
        chk(64'(wake_cnt - w0), 64'd0, "R11 disabled pin no wake");
        rd(32'h5C, 32'h8, "R11 disabled pin still pending");

        // R9 beyond width
        wr(32'h30, 32'hFFFF_FFFF);
        rd(32'h30, 32'h000F_FFFF, "R9 bank1 any-edge width");
        @(negedge clk); pin_in[63:52] = 12'hFFF; pin_in[95:72] = 24'hFFFFFF;
        idle(4);
        rd(32'h3C, 32'h1, "R9 no pending above width");
        chk(64'(pin_oe[63:52]), 64'd0, "R9 no drive above width");

        // R10 merge across banks
        wr(32'h3C, 32'hFFFF_FFFF);
        chk(64'(irq), 64'd0, "R10 disabled pending hidden");
        wr(32'h54, 32'h28);
        chk(64'(irq), 64'd1, "R10 other bank raises irq");
        wr(32'h5C, 32'hFFFF_FFFF);
        chk(64'(irq), 64'd0, "R10 all cleared");

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule